// File: doc/BRIEF.md
# Aliased Display I/O Port Decoder

This block is the byte-wide I/O front end of a legacy display controller. It takes a single-cycle read or write strobe with a 10-bit port address and a byte of write data. It turns valid accesses into index updates, register-file write requests and read data. The CRT controller, the status port and the CRT index and data ports exist twice in the port space, once in the monochrome group (0x3B0 to 0x3BF) and once in the color group (0x3D0 to 0x3DF). Bit 0 of the miscellaneous output byte, held inside the block, chooses which group answers. The other group is silently blocked. The shared group 0x3C0 to 0x3CF is always active.

The block holds the sequencer, CRT and attribute index registers and the attribute index/data toggle. It also holds the miscellaneous output byte. It forwards data-port writes to the register files outside it as a one-cycle write request carrying target, index and data. Writes that alter display timing produce a one-cycle change pulse for the timing engine. The status port passes through a byte supplied by the timing engine, and a read of that port returns the attribute toggle to its index phase.

Top module: `dispio_port_decode`

## Requirements
- R1: After synchronous reset the miscellaneous byte is 0x00, which selects monochrome. The attribute toggle is in its index phase, all three index registers are zero, and no read, write or change output is asserted.
- R2: With miscellaneous bit 0 set, ports 0x3B0–0x3BF are blocked. With it clear, ports 0x3D0–0x3DF are blocked. A read of a blocked port returns 0xFF with rd_valid, one cycle after the strobe.
- R3: A write to a blocked port changes no index register, the toggle and the miscellaneous byte, and raises neither reg_wr nor timing_chg. A read of a blocked port leaves the attribute toggle unchanged.
- R4: A read of offset 0xA in the active CRT group returns the status_in byte as sampled at the strobe edge. It also puts the attribute toggle in its index phase.
- R5: A write to 0x3C2 loads the miscellaneous byte with bit 4 forced to 0. A read of 0x3CC returns the miscellaneous byte.
- R6: Writing 0x3C4 sets the sequencer index, and writing offset 0x4 of the active CRT group sets the CRT index. Reads of these ports return the index. A write to 0x3C5 gives a reg_wr with target 1, and a write to offset 0x5 of the active CRT group gives target 2. Each request carries the current index and the data, one cycle after the strobe.
- R7: A write to 0x3C0 in the index phase loads the attribute index, raises no reg_wr and moves the toggle to the data phase. A write in the data phase gives reg_wr with target 3 and the attribute index, and returns the toggle to the index phase. attr_data_phase shows the phase, and a read of 0x3C0 returns the attribute index.
- R8: timing_chg pulses for one cycle, one cycle after any of these writes: 0x3C2; 0x3C5 while the sequencer index is 1; a CRT data write while the CRT index is 0x00, 0x02, 0x03, 0x05, 0x06, 0x07, 0x09, 0x10, 0x11, 0x15 or 0x16. No other access pulses it.
- R9: When bus_rd and bus_wr are both asserted, the read is performed and the write is discarded.
- R10: A read of any other non-blocked port, such as 0x3C1 or 0x3C2, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 10 | Port address |
| bus_wdata | input | 8 | Write data |
| status_in | input | 8 | Status byte from the timing engine |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| misc_q | output | 8 | Miscellaneous output byte |
| color_mode | output | 1 | Color group active |
| attr_data_phase | output | 1 | Attribute toggle in data phase |
| reg_wr | output | 1 | Register-file write request |
| reg_target | output | 2 | 1 sequencer, 2 CRT, 3 attribute |
| reg_index | output | 8 | Register index for the request |
| reg_wdata | output | 8 | Data for the request |
| timing_chg | output | 1 | Timing-relevant register written |

## Verification
Every result of this block comes from a single register stage. Read data, write requests and the change pulse therefore all appear in the cycle after the strobe edge, and the index, toggle and miscellaneous state take their new values on that same edge. The driver applies each access at a falling edge and records what is expected for it. The monitor takes that record at the next rising edge and compares the outputs at the falling edge after it. So every comparison falls exactly one cycle after its strobe. A cycle with no recorded access must show no rd_valid, reg_wr or timing_chg. This is how discarded writes and blocked ports are caught.

// File: rtl/dispio_pkg.sv
package dispio_pkg;

  // Register-file target codes carried on reg_target.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SEQ  = 2'd1,
    TGT_CRTC = 2'd2,
    TGT_ATTR = 2'd3
  } tgt_e;

  // Decoded port kinds.
  typedef enum logic [3:0] {
    PK_NONE,
    PK_BLOCKED,
    PK_MISC_WR,
    PK_MISC_RD,
    PK_SEQ_IDX,
    PK_SEQ_DAT,
    PK_CRT_IDX,
    PK_CRT_DAT,
    PK_STATUS,
    PK_ATTR
  } port_kind_e;

endpackage

// File: rtl/dispio_addr_decode.sv
module dispio_addr_decode
  import dispio_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int MONO_BASE  = 'h3B0,
  parameter int COLOR_BASE = 'h3D0,
  parameter int SHARE_BASE = 'h3C0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              color,
  output port_kind_e        kind
);
  localparam int GRP_W = ADDR_W - 4;
  localparam logic [GRP_W-1:0] MONO_GRP  = GRP_W'(MONO_BASE >> 4);
  localparam logic [GRP_W-1:0] COLOR_GRP = GRP_W'(COLOR_BASE >> 4);
  localparam logic [GRP_W-1:0] SHARE_GRP = GRP_W'(SHARE_BASE >> 4);

  logic [GRP_W-1:0] grp;
  logic [3:0]       ofs;
  logic             in_mono, in_color, crt_hit, blocked;

  always_comb begin
    grp      = addr[ADDR_W-1:4];
    ofs      = addr[3:0];
    in_mono  = (grp == MONO_GRP);
    in_color = (grp == COLOR_GRP);
    // the CRT group follows the mode bit; the other one is shut off
    crt_hit  = (in_mono && !color) || (in_color && color);
    blocked  = (in_mono && color) || (in_color && !color);
    kind     = PK_NONE;
    if (blocked) begin
      kind = PK_BLOCKED;
    end else if (crt_hit) begin
      case (ofs)
        4'h4:    kind = PK_CRT_IDX;
        4'h5:    kind = PK_CRT_DAT;
        4'hA:    kind = PK_STATUS;
        default: kind = PK_NONE;
      endcase
    end else if (grp == SHARE_GRP) begin
      case (ofs)
        4'h0:    kind = PK_ATTR;
        4'h2:    kind = PK_MISC_WR;
        4'h4:    kind = PK_SEQ_IDX;
        4'h5:    kind = PK_SEQ_DAT;
        4'hC:    kind = PK_MISC_RD;
        default: kind = PK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dispio_index_bank.sv
module dispio_index_bank
  import dispio_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic             wr,
  input  port_kind_e       kind,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] seq_idx,
  output logic [IDX_W-1:0] crt_idx,
  output logic [IDX_W-1:0] attr_idx,
  output logic             attr_ff
);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_idx  <= '0;
      crt_idx  <= '0;
      attr_idx <= '0;
      attr_ff  <= 1'b0;
    end else begin
      if (rd && kind == PK_STATUS) begin
        attr_ff <= 1'b0;
      end
      if (wr) begin
        case (kind)
          PK_SEQ_IDX: seq_idx <= wdata;
          PK_CRT_IDX: crt_idx <= wdata;
          PK_ATTR: begin
            if (!attr_ff) attr_idx <= wdata;
            attr_ff <= !attr_ff;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dispio_notify.sv
module dispio_notify
  import dispio_pkg::*;
#(
  parameter int                 IDX_W          = 8,
  parameter int                 CRT_MAP_W      = 32,
  parameter logic [CRT_MAP_W-1:0] CRT_MAP      = 32'h0063_02ED,
  parameter int                 SEQ_NOTIFY_IDX = 1
) (
  input  logic             wr,
  input  port_kind_e       kind,
  input  logic [IDX_W-1:0] seq_idx,
  input  logic [IDX_W-1:0] crt_idx,
  output logic             hit
);
  logic [CRT_MAP_W-1:0] crt_match;

  genvar gi;
  generate
    for (gi = 0; gi < CRT_MAP_W; gi++) begin : g_crt
      if (CRT_MAP[gi]) begin : g_on
        assign crt_match[gi] = (int'(crt_idx) == gi);
      end else begin : g_off
        assign crt_match[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    if (wr) begin
      case (kind)
        PK_MISC_WR: hit = 1'b1;
        PK_SEQ_DAT: hit = (int'(seq_idx) == SEQ_NOTIFY_IDX);
        PK_CRT_DAT: hit = |crt_match;
        default:    hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/dispio_port_decode.sv
module dispio_port_decode
  import dispio_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int MONO_BASE  = 'h3B0,
  parameter int COLOR_BASE = 'h3D0,
  parameter int SHARE_BASE = 'h3C0,
  parameter int MODE_BIT   = 0,
  parameter int FORCE0_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] status_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] misc_q,
  output logic              color_mode,
  output logic              attr_data_phase,
  output logic              reg_wr,
  output logic [1:0]        reg_target,
  output logic [DATA_W-1:0] reg_index,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              timing_chg
);
  localparam logic [DATA_W-1:0] MISC_KEEP = ~(DATA_W'(1) << FORCE0_BIT);
  localparam logic [DATA_W-1:0] BLOCK_VAL = '1;

  port_kind_e        kind;
  logic              wr_eff;
  logic [DATA_W-1:0] seq_idx, crt_idx, attr_idx;
  logic              attr_ff, chg_hit;
  logic [DATA_W-1:0] rd_next;
  logic              fwd_next;
  tgt_e              tgt_next;
  logic [DATA_W-1:0] idx_next;

  // a read wins over a write in the same cycle
  assign wr_eff = bus_wr && !bus_rd;

  dispio_addr_decode #(
    .ADDR_W(ADDR_W), .MONO_BASE(MONO_BASE),
    .COLOR_BASE(COLOR_BASE), .SHARE_BASE(SHARE_BASE)
  ) u_dec (
    .addr (bus_addr),
    .color(misc_q[MODE_BIT]),
    .kind (kind)
  );

  dispio_index_bank #(.IDX_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .wr      (wr_eff),
    .kind    (kind),
    .wdata   (bus_wdata),
    .seq_idx (seq_idx),
    .crt_idx (crt_idx),
    .attr_idx(attr_idx),
    .attr_ff (attr_ff)
  );

  dispio_notify #(.IDX_W(DATA_W)) u_ntf (
    .wr     (wr_eff),
    .kind   (kind),
    .seq_idx(seq_idx),
    .crt_idx(crt_idx),
    .hit    (chg_hit)
  );

  always_comb begin
    case (kind)
      PK_BLOCKED: rd_next = BLOCK_VAL;
      PK_STATUS:  rd_next = status_in;
      PK_MISC_RD: rd_next = misc_q;
      PK_SEQ_IDX: rd_next = seq_idx;
      PK_CRT_IDX: rd_next = crt_idx;
      PK_ATTR:    rd_next = attr_idx;
      default:    rd_next = '0;
    endcase
  end

  always_comb begin
    fwd_next = 1'b0;
    tgt_next = TGT_NONE;
    idx_next = '0;
    if (wr_eff) begin
      case (kind)
        PK_SEQ_DAT: begin fwd_next = 1'b1; tgt_next = TGT_SEQ;  idx_next = seq_idx;  end
        PK_CRT_DAT: begin fwd_next = 1'b1; tgt_next = TGT_CRTC; idx_next = crt_idx;  end
        PK_ATTR: if (attr_ff) begin
          fwd_next = 1'b1; tgt_next = TGT_ATTR; idx_next = attr_idx;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      reg_wr     <= 1'b0;
      reg_target <= TGT_NONE;
      reg_index  <= '0;
      reg_wdata  <= '0;
      timing_chg <= 1'b0;
    end else begin
      if (wr_eff && kind == PK_MISC_WR) misc_q <= bus_wdata & MISC_KEEP;
      rd_valid   <= bus_rd;
      rd_data    <= bus_rd ? rd_next : '0;
      reg_wr     <= fwd_next;
      reg_target <= tgt_next;
      reg_index  <= idx_next;
      reg_wdata  <= fwd_next ? bus_wdata : '0;
      timing_chg <= chg_hit;
    end
  end

  assign color_mode      = misc_q[MODE_BIT];
  assign attr_data_phase = attr_ff;

endmodule

// File: rtl/dispio_port_decode_chk.sv
module dispio_port_decode_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              rd_valid,
  input logic              reg_wr,
  input logic [1:0]        reg_target,
  input logic [DATA_W-1:0] misc_q,
  input logic              attr_data_phase,
  input logic              timing_chg
);
  // R2
  rd_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_rd));
  // R6
  fwd_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> $past(bus_wr && !bus_rd));
  // R9
  no_rd_and_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && reg_wr));
  // R7
  attr_fwd_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_target == 2'd3) |-> (!attr_data_phase && $past(attr_data_phase)));
  // R8
  chg_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    timing_chg |-> $past(bus_wr && !bus_rd));
  // R5
  misc_bit4_low_chk: assert property (@(posedge clk) disable iff (rst)
    misc_q[4] == 1'b0);
  // R3
  misc_moves_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(misc_q) |-> ($past(bus_wr) && timing_chg));
endmodule

bind dispio_port_decode dispio_port_decode_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .rd_valid(rd_valid), .reg_wr(reg_wr), .reg_target(reg_target),
  .misc_q(misc_q), .attr_data_phase(attr_data_phase), .timing_chg(timing_chg)
);

// File: tb/dispio_port_decode_bench.sv
`timescale 1ns/1ps
module dispio_port_decode_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, status_in = 8'h09;
  logic       rd_valid, color_mode, attr_data_phase, reg_wr, timing_chg;
  logic [7:0] rd_data, misc_q, reg_index, reg_wdata;
  logic [1:0] reg_target;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic       rv;
    logic [7:0] rdat;
    logic       wv;
    logic [1:0] tgt;
    logic [7:0] idx;
    logic [7:0] wd;
    logic       chg;
    string      tag;
  } exp_t;
  exp_t q[$];

  // bench model of the visible state, built from the requirements
  logic [7:0] m_misc = 0, m_seq = 0, m_crt = 0, m_attr = 0;
  logic       m_ff = 0;
  localparam logic [31:0] CRT_CHG = 32'h0063_02ED;

  always #2 clk = ~clk;

  dispio_port_decode u_dispio_port_decode (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_in(status_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .misc_q(misc_q),
    .color_mode(color_mode), .attr_data_phase(attr_data_phase),
    .reg_wr(reg_wr), .reg_target(reg_target), .reg_index(reg_index),
    .reg_wdata(reg_wdata), .timing_chg(timing_chg)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input bit rd, input bit wr, input logic [9:0] a,
                        input logic [7:0] d, input string tag);
    exp_t e;
    bit color, blocked, crt;
    color   = m_misc[0];
    blocked = color ? (a[9:4] == 6'h3B) : (a[9:4] == 6'h3D);
    crt     = color ? (a[9:4] == 6'h3D) : (a[9:4] == 6'h3B);
    e = '{rv: rd, rdat: 8'h00, wv: 0, tgt: 0, idx: 0, wd: 0, chg: 0, tag: tag};
    if (rd) begin
      if (blocked) e.rdat = 8'hFF;
      else if (crt && a[3:0] == 4'h4) e.rdat = m_crt;
      else if (crt && a[3:0] == 4'hA) begin e.rdat = status_in; m_ff = 0; end
      else if (a == 10'h3CC) e.rdat = m_misc;
      else if (a == 10'h3C4) e.rdat = m_seq;
      else if (a == 10'h3C0) e.rdat = m_attr;
    end else if (wr && !blocked) begin
      if (a == 10'h3C2) begin m_misc = d & 8'hEF; e.chg = 1; end
      else if (a == 10'h3C4) m_seq = d;
      else if (a == 10'h3C5) begin
        e.wv = 1; e.tgt = 1; e.idx = m_seq; e.wd = d; e.chg = (m_seq == 8'd1);
      end
      else if (crt && a[3:0] == 4'h4) m_crt = d;
      else if (crt && a[3:0] == 4'h5) begin
        e.wv = 1; e.tgt = 2; e.idx = m_crt; e.wd = d;
        e.chg = (m_crt < 8'd32) && CRT_CHG[m_crt[4:0]];
      end
      else if (a == 10'h3C0) begin
        if (m_ff) begin e.wv = 1; e.tgt = 3; e.idx = m_attr; e.wd = d; end
        else m_attr = d;
        m_ff = !m_ff;
      end
    end
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    q.push_back(e);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    check(misc_q == m_misc && color_mode == m_misc[0], {tag, " misc state"}, misc_q, m_misc);
    check(attr_data_phase == m_ff, {tag, " attr phase"}, attr_data_phase, m_ff);
  endtask

  // monitor: result of a strobe is due at the falling edge one cycle later
  initial begin
    exp_t e;
    bit have;
    forever begin
      @(posedge clk);
      have = q.size() > 0;
      if (have) e = q.pop_front();
      @(negedge clk);
      if (!rst) begin
        if (have) begin
          check(rd_valid == e.rv, {e.tag, " rd_valid"}, rd_valid, e.rv);
          if (e.rv) check(rd_data == e.rdat, {e.tag, " rd_data"}, rd_data, e.rdat);
          check(reg_wr == e.wv, {e.tag, " reg_wr"}, reg_wr, e.wv);
          if (e.wv) check({reg_target, reg_index, reg_wdata} == {e.tgt, e.idx, e.wd},
                          {e.tag, " request"}, {reg_target, reg_index, reg_wdata},
                          {e.tgt, e.idx, e.wd});
          check(timing_chg == e.chg, {e.tag, " timing_chg"}, timing_chg, e.chg);
        end else if (rd_valid || reg_wr || timing_chg) begin
          errors++;
          $display("FAIL idle cycle activity: actual %b%b%b expected 000",
                   rd_valid, reg_wr, timing_chg);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(misc_q == 0 && !color_mode, "R1 misc after reset", misc_q, 0);
    check(!attr_data_phase, "R1 toggle after reset", attr_data_phase, 0);
    check(!rd_valid && !reg_wr && !timing_chg, "R1 outputs idle", {rd_valid, reg_wr, timing_chg}, 0);
    bus_op(1, 0, 10'h3B4, 0, "R1 crt index zero");
    // mono mode: color group blocked (R2, R3)
    bus_op(1, 0, 10'h3D4, 0, "R2 blocked read mono");
    bus_op(0, 1, 10'h3D4, 8'h11, "R3 blocked index write");
    bus_op(0, 1, 10'h3D5, 8'h22, "R3 blocked data write");
    bus_op(1, 0, 10'h3B4, 0, "R3 index unchanged");
    // CRT index/data and change pulse (R6, R8)
    bus_op(0, 1, 10'h3B4, 8'h07, "R6 crt index");
    bus_op(1, 0, 10'h3B4, 0, "R6 crt index read");
    bus_op(0, 1, 10'h3B5, 8'hAA, "R8 crt 07 notify");
    bus_op(0, 1, 10'h3B4, 8'h08, "R6 crt index 08");
    bus_op(0, 1, 10'h3B5, 8'h5A, "R8 crt 08 quiet");
    bus_op(0, 1, 10'h3B4, 8'h16, "R6 crt index 16");
    bus_op(0, 1, 10'h3B5, 8'h3C, "R8 crt 16 notify");
    bus_op(0, 1, 10'h3B4, 8'h30, "R6 crt index 30");
    bus_op(0, 1, 10'h3B5, 8'h01, "R8 crt 30 quiet");
    // sequencer (R6, R8)
    bus_op(0, 1, 10'h3C4, 8'h01, "R6 seq index");
    bus_op(1, 0, 10'h3C4, 0, "R6 seq index read");
    bus_op(0, 1, 10'h3C5, 8'h21, "R8 seq 01 notify");
    bus_op(0, 1, 10'h3C4, 8'h02, "R6 seq index 02");
    bus_op(0, 1, 10'h3C5, 8'h0F, "R8 seq 02 quiet");
    // attribute toggle (R7, R4)
    bus_op(0, 1, 10'h3C0, 8'h10, "R7 attr index phase");
    bus_op(0, 1, 10'h3C0, 8'h55, "R7 attr data phase");
    bus_op(0, 1, 10'h3C0, 8'h12, "R7 attr index again");
    bus_op(1, 0, 10'h3DA, 0, "R3 blocked status keeps toggle");
    status_in = 8'h01;
    bus_op(1, 0, 10'h3BA, 0, "R4 status read clears toggle");
    bus_op(1, 0, 10'h3C0, 0, "R7 attr index read");
    bus_op(0, 1, 10'h3C0, 8'h13, "R7 attr index after clear");
    bus_op(0, 1, 10'h3C0, 8'h66, "R7 attr data after clear");
    // misc register (R5), switch to color
    bus_op(0, 1, 10'h3C2, 8'hFF, "R5 misc write bit4 cleared");
    bus_op(1, 0, 10'h3CC, 0, "R5 misc read");
    bus_op(1, 0, 10'h3B4, 0, "R2 blocked read color");
    bus_op(0, 1, 10'h3B4, 8'h02, "R3 blocked mono write");
    bus_op(1, 0, 10'h3D4, 0, "R6 color crt index read");
    bus_op(0, 1, 10'h3D4, 8'h09, "R6 color crt index");
    bus_op(0, 1, 10'h3D5, 8'h77, "R8 color crt 09 notify");
    bus_op(0, 1, 10'h3C0, 8'h04, "R7 attr index color");
    status_in = 8'h08;
    bus_op(1, 0, 10'h3DA, 0, "R4 color status read");
    // read and write together (R9)
    bus_op(1, 1, 10'h3C4, 8'h05, "R9 read wins");
    bus_op(1, 0, 10'h3C4, 0, "R9 seq index unchanged");
    bus_op(1, 1, 10'h3C2, 8'h00, "R9 misc write dropped");
    // other ports (R10)
    bus_op(1, 0, 10'h3C1, 0, "R10 unmapped read");
    bus_op(1, 0, 10'h3C2, 0, "R10 misc write port read");
    bus_op(0, 1, 10'h3C2, 8'h00, "R5 back to mono");
    bus_op(1, 0, 10'h3DA, 0, "R2 blocked after switch");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R6 scoreboard drained", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule